// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is a bank of general-purpose pins behind a small word-addressed register port. Software picks a direction for each pin, writes output levels, reads back the sensed level of every pad, and arms each pin to raise an interrupt on a level, a single edge, or both edges. Reads are combinational from the registers; writes take effect at the clock edge on which the write strobe is sampled.

Every pad input passes through a two-flop synchronizer. Trigger detection compares the synchronized level with its value one cycle earlier. Detected events set sticky status bits whether or not the pin is masked. Software clears status bits by writing ones. The masked status of the lower half of the bank drives one interrupt line, and that of the upper half drives the other.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted and after its release, every pin is an input (`padOe` = 0). The data, mask, status and edge-select registers read 0, and both interrupt outputs are low.
- R2: A write to offset 0x04 sets the per-pin output enable, with 1 meaning output, and `padOe` follows it from the next cycle. A write to offset 0x00 sets the output levels, and `padOut` carries them.
- R3: A read of offset 0x00 returns the data register bit for output pins and the synchronized pad level for input pins.
- R4: A read of offset 0x08 returns the synchronized pad level of every pin regardless of direction. A pad change becomes visible there after two clock edges.
- R5: The trigger field of pin n is 2 bits wide. For pins below 16 it sits at bit 2*n of the register at offset 0x0C. For pins 16 to 31 it sits at bit 2*(n-16) of the register at offset 0x10. Both registers read back exactly what was written.
- R6: Field value 00 triggers while the synchronized level is low, and 01 triggers while it is high. A level trigger re-sets its status bit on every cycle the level holds, so a clear during that time has no effect.
- R7: Field value 10 triggers only on a rising edge and 11 only on a falling edge. An edge sets status once, and the opposite edge sets nothing.
- R8: When a pin's bit at offset 0x1C is 1, the pin triggers on both edges and its trigger field is ignored.
- R9: At offset 0x18, status bits written with 1 are cleared and bits written with 0 are unchanged. Without such a write no status bit falls.
- R10: If a clear and a new event hit the same status bit in the same cycle, the bit ends up set.
- R11: Status bits are set regardless of the mask at offset 0x14, but only status bits whose mask bit is 1 reach an interrupt output.
- R12: `irqLow` is the OR of masked status for pins 0 to 15, and `irqHigh` is the OR for pins 16 to 31.
- R13: An edge event on a pad shows up in the status register after the third clock edge following the pad change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Byte offset of the register being accessed |
| busWrite | input | 1 | Write strobe, sampled at the rising clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| padIn | input | 32 | Raw pad levels, asynchronous to clk |
| padOut | output | 32 | Output levels driven toward the pads |
| padOe | output | 32 | Per-pin output enable |
| irqLow | output | 1 | Interrupt request for pins 0 to 15 |
| irqHigh | output | 1 | Interrupt request for pins 16 to 31 |

## Verification
The bench builds the bank with its default parameters: 32 pins, a 5-bit address and two synchronizer stages. With 32 pins, the half-bank split falls at pin 16, so both configuration registers are fully populated and each interrupt line can be shown responding to its own half while the other stays quiet. With two synchronizer stages, the edge-to-status latency is three edges. The bench uses this to place a status clear on the very edge where a new rising event lands, and to confirm that the status register is still clean one edge before that point.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

  // register index = byte offset / 4; the offsets are fixed by software
  typedef enum logic [2:0] {
    RSEL_DATA   = 3'd0,
    RSEL_DIR    = 3'd1,
    RSEL_PAD    = 3'd2,
    RSEL_CFGLO  = 3'd3,
    RSEL_CFGHI  = 3'd4,
    RSEL_MASK   = 3'd5,
    RSEL_STATUS = 3'd6,
    RSEL_EDGE   = 3'd7
  } regSel_t;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_t;

  // write strobes handed from control to datapath
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrCfgLo;
    logic wrCfgHi;
    logic wrMask;
    logic wrStatus;
    logic wrEdge;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
`timescale 1ns/1ps
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output ctrlStrobe_t       strobes,
  output regSel_t           rdSel,
  output logic              rdHit
);
  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned SPAN_W  = IDX_LSB + IDX_W;

  logic    upperZero;
  logic    aligned;
  regSel_t idx;

  generate
    if (ADDR_W > SPAN_W) begin : g_upper
      assign upperZero = ~|busAddr[ADDR_W-1:SPAN_W];
    end else begin : g_noUpper
      assign upperZero = 1'b1;
    end
  endgenerate

  assign aligned = ~|busAddr[IDX_LSB-1:0];
  assign idx     = regSel_t'(busAddr[IDX_LSB +: IDX_W]);
  assign rdSel   = idx;
  assign rdHit   = upperZero & aligned;

  always_comb begin
    strobes = '0;
    if (busWrite && rdHit) begin
      case (idx)
        RSEL_DATA:   strobes.wrData   = 1'b1;
        RSEL_DIR:    strobes.wrDir    = 1'b1;
        RSEL_CFGLO:  strobes.wrCfgLo  = 1'b1;
        RSEL_CFGHI:  strobes.wrCfgHi  = 1'b1;
        RSEL_MASK:   strobes.wrMask   = 1'b1;
        RSEL_STATUS: strobes.wrStatus = 1'b1;
        RSEL_EDGE:   strobes.wrEdge   = 1'b1;
        default:     strobes = '0;  // pad level is read-only
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_sync.sv
`timescale 1ns/1ps
module gpio_bank_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stageQ[s] <= '0;
          else        stageQ[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stageQ[s] <= '0;
          else        stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/gpio_bank_trigger.sv
`timescale 1ns/1ps
module gpio_bank_trigger
  import gpio_bank_pkg::*;
(
  input  logic       levelNow,
  input  logic       levelPrev,
  input  logic       bothEdges,
  input  logic [1:0] mode,
  output logic       hit
);
  always_comb begin
    if (bothEdges) begin
      hit = levelNow ^ levelPrev;  // override: mode field is ignored
    end else begin
      case (trig_t'(mode))
        TRIG_LOW:  hit = ~levelNow;
        TRIG_HIGH: hit = levelNow;
        TRIG_RISE: hit = levelNow & ~levelPrev;
        TRIG_FALL: hit = ~levelNow & levelPrev;
        default:   hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_datapath.sv
`timescale 1ns/1ps
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctrlStrobe_t     strobes,
  input  regSel_t         rdSel,
  input  logic            rdHit,
  input  logic [PINS-1:0] wdata,
  input  logic [PINS-1:0] padIn,
  output logic [PINS-1:0] rdata,
  output logic [PINS-1:0] padOut,
  output logic [PINS-1:0] padOe,
  output logic            irqLow,
  output logic            irqHigh,
  output logic [PINS-1:0] statusVec,
  output logic [PINS-1:0] maskVec,
  output logic [PINS-1:0] edgeSelVec,
  output logic [PINS-1:0] cfgLoVec,
  output logic [PINS-1:0] cfgHiVec,
  output logic [PINS-1:0] syncVec
);
  localparam int unsigned HALF = PINS / 2;

  logic [PINS-1:0] dataQ, dirQ, cfgLoQ, cfgHiQ, maskQ, statusQ, edgeQ, prevQ;
  logic [PINS-1:0] syncQ, pinEvt, clrBits, maskedQ;

  gpio_bank_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (padIn),
    .dout (syncQ)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataQ  <= '0;
      dirQ   <= '0;
      cfgLoQ <= '0;
      cfgHiQ <= '0;
      maskQ  <= '0;
      edgeQ  <= '0;
      prevQ  <= '0;
    end else begin
      if (strobes.wrData)  dataQ  <= wdata;
      if (strobes.wrDir)   dirQ   <= wdata;
      if (strobes.wrCfgLo) cfgLoQ <= wdata;
      if (strobes.wrCfgHi) cfgHiQ <= wdata;
      if (strobes.wrMask)  maskQ  <= wdata;
      if (strobes.wrEdge)  edgeQ  <= wdata;
      prevQ <= syncQ;
    end
  end

  // one trigger unit per pin; field location depends on the half
  generate
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      logic [1:0] modeField;
      if (p < HALF) begin : g_lo
        assign modeField = cfgLoQ[2*p +: 2];
      end else begin : g_hi
        assign modeField = cfgHiQ[2*(p-HALF) +: 2];
      end
      gpio_bank_trigger u_trig (
        .levelNow (syncQ[p]),
        .levelPrev(prevQ[p]),
        .bothEdges(edgeQ[p]),
        .mode     (modeField),
        .hit      (pinEvt[p])
      );
    end
  endgenerate

  // sticky status: a fresh event outranks a same-cycle clear
  assign clrBits = strobes.wrStatus ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statusQ <= '0;
    else        statusQ <= (statusQ & ~clrBits) | pinEvt;
  end

  assign maskedQ = statusQ & maskQ;
  assign irqLow  = |maskedQ[HALF-1:0];
  assign irqHigh = |maskedQ[PINS-1:HALF];

  always_comb begin
    rdata = '0;
    if (rdHit) begin
      case (rdSel)
        RSEL_DATA:   rdata = (dataQ & dirQ) | (syncQ & ~dirQ);
        RSEL_DIR:    rdata = dirQ;
        RSEL_PAD:    rdata = syncQ;
        RSEL_CFGLO:  rdata = cfgLoQ;
        RSEL_CFGHI:  rdata = cfgHiQ;
        RSEL_MASK:   rdata = maskQ;
        RSEL_STATUS: rdata = statusQ;
        RSEL_EDGE:   rdata = edgeQ;
        default:     rdata = '0;
      endcase
    end
  end

  assign padOut     = dataQ;
  assign padOe      = dirQ;
  assign statusVec  = statusQ;
  assign maskVec    = maskQ;
  assign edgeSelVec = edgeQ;
  assign cfgLoVec   = cfgLoQ;
  assign cfgHiVec   = cfgHiQ;
  assign syncVec    = syncQ;
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS        = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [PINS-1:0]   busWdata,
  output logic [PINS-1:0]   busRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic              irqLow,
  output logic              irqHigh
);
  ctrlStrobe_t     strobes;
  regSel_t         rdSel;
  logic            rdHit;
  logic [PINS-1:0] statusVec, maskVec, edgeSelVec, cfgLoVec, cfgHiVec, syncVec;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrite(busWrite),
    .strobes (strobes),
    .rdSel   (rdSel),
    .rdHit   (rdHit)
  );

  gpio_bank_datapath #(.PINS(PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .rdSel     (rdSel),
    .rdHit     (rdHit),
    .wdata     (busWdata),
    .padIn     (padIn),
    .rdata     (busRdata),
    .padOut    (padOut),
    .padOe     (padOe),
    .irqLow    (irqLow),
    .irqHigh   (irqHigh),
    .statusVec (statusVec),
    .maskVec   (maskVec),
    .edgeSelVec(edgeSelVec),
    .cfgLoVec  (cfgLoVec),
    .cfgHiVec  (cfgHiVec),
    .syncVec   (syncVec)
  );
endmodule

// File: rtl/gpio_bank_checker.sv
`timescale 1ns/1ps
module gpio_bank_checker #(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic [PINS-1:0]   busWdata,
  input logic [PINS-1:0]   padOe,
  input logic              irqLow,
  input logic              irqHigh,
  input logic [PINS-1:0]   statusVec,
  input logic [PINS-1:0]   maskVec,
  input logic [PINS-1:0]   edgeSelVec,
  input logic [PINS-1:0]   cfgLoVec,
  input logic [PINS-1:0]   cfgHiVec,
  input logic [PINS-1:0]   syncVec
);
  localparam int unsigned HALF = PINS / 2;
  localparam logic [ADDR_W-1:0] OFS_DIR  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(24);

  logic [PINS-1:0] syncD, bothEvt, lvlHiEvt, maskedV;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncD <= '0;
    else        syncD <= syncVec;
  end

  generate
    for (genvar p = 0; p < PINS; p++) begin : g_ref
      logic [1:0] fld;
      if (p < HALF) begin : g_lo
        assign fld = cfgLoVec[2*p +: 2];
      end else begin : g_hi
        assign fld = cfgHiVec[2*(p-HALF) +: 2];
      end
      assign lvlHiEvt[p] = ~edgeSelVec[p] & (fld == 2'b01) & syncVec[p];
    end
  endgenerate

  assign bothEvt = edgeSelVec & (syncVec ^ syncD);
  assign maskedV = statusVec & maskVec;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!irqLow && !irqHigh));

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrite && busAddr == OFS_DIR) |=> (padOe == $past(busWdata)));

  assert_level_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvlHiEvt != '0) |=> ((statusVec & $past(lvlHiEvt)) == $past(lvlHiEvt)));

  assert_both_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bothEvt != '0) |=> ((statusVec & $past(bothEvt)) == $past(bothEvt)));

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busWrite && busAddr == OFS_STAT) |=> ((statusVec & $past(statusVec)) == $past(statusVec)));

  assert_mask_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (maskedV[HALF-1:0] == '0) |-> !irqLow);

  assert_mask_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (maskedV[PINS-1:HALF] == '0) |-> !irqHigh);

  assert_irq_split_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (maskedV[HALF-1:0] != '0) |-> irqLow);
endmodule

bind gpio_bank gpio_bank_checker #(.PINS(PINS), .ADDR_W(ADDR_W)) u_gpio_bank_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .busAddr   (busAddr),
  .busWrite  (busWrite),
  .busWdata  (busWdata),
  .padOe     (padOe),
  .irqLow    (irqLow),
  .irqHigh   (irqHigh),
  .statusVec (statusVec),
  .maskVec   (maskVec),
  .edgeSelVec(edgeSelVec),
  .cfgLoVec  (cfgLoVec),
  .cfgHiVec  (cfgHiVec),
  .syncVec   (syncVec)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
  localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08, A_CFGLO = 5'h0C;
  localparam logic [4:0] A_CFGHI = 5'h10, A_MASK = 5'h14, A_STAT = 5'h18, A_EDGE = 5'h1C;
  localparam int K_RD = 0, K_IRQL = 1, K_IRQH = 2, K_OE = 3, K_OUT = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  busAddr;
  logic        busWrite;
  logic [31:0] busWdata, busRdata, padIn, padOut, padOe;
  logic        irqLow, irqHigh;

  always #4 clk = ~clk;  // 125 MHz

  gpio_bank u_gpio_bank (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .irqLow(irqLow), .irqHigh(irqHigh)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbQ[$];
  int    total = 0;
  int    bad   = 0;
  bit    done  = 1'b0;
  event  sampleEv;

  // monitor: pops the next expectation and compares it with the live outputs
  always @(sampleEv) begin : monitor
    item_t       it;
    logic [31:0] act;
    it = sbQ.pop_front();
    case (it.kind)
      K_IRQL:  act = {31'b0, irqLow};
      K_IRQH:  act = {31'b0, irqHigh};
      K_OE:    act = padOe;
      K_OUT:   act = padOut;
      default: act = busRdata;
    endcase
    total++;
    if (act !== it.exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expectVal(int kind, logic [4:0] addr, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    busAddr = addr;
    sbQ.push_back(it);
    #0.1;
    ->sampleEv;
    #0.1;
  endtask

  task automatic rdChk(logic [4:0] addr, logic [31:0] exp, string tag);
    expectVal(K_RD, addr, exp, tag);
  endtask

  task automatic wr(logic [4:0] addr, logic [31:0] data);
    busAddr  = addr;
    busWdata = data;
    busWrite = 1'b1;
    step();
    busWrite = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      summary();
    end
  end

  initial begin : driver
    logic [31:0] dirM, dataM;
    rst_n    = 1'b0;
    busWrite = 1'b0;
    busAddr  = '0;
    busWdata = '0;
    padIn    = 32'hFFFF_FFF9;  // pins 1 and 2 low
    repeat (3) step();

    // R1: reset state
    rdChk(A_STAT, 32'h0, "R1 status in reset");
    rdChk(A_DIR,  32'h0, "R1 direction in reset");
    rdChk(A_MASK, 32'h0, "R1 mask in reset");
    rdChk(A_EDGE, 32'h0, "R1 edge select in reset");
    rdChk(A_DATA, 32'h0, "R1 data in reset");
    expectVal(K_OE,   A_DATA, 32'h0, "R1 padOe in reset");
    expectVal(K_IRQL, A_DATA, 32'h0, "R1 irqLow in reset");
    expectVal(K_IRQH, A_DATA, 32'h0, "R1 irqHigh in reset");

    rst_n = 1'b1;
    repeat (4) step();
    expectVal(K_IRQL, A_DATA, 32'h0, "R1 irqLow after reset");

    // R5: config register readback and field layout
    wr(A_CFGLO, 32'h1234_5678);
    wr(A_CFGHI, 32'h9ABC_DEF0);
    rdChk(A_CFGLO, 32'h1234_5678, "R5 low config readback");
    rdChk(A_CFGHI, 32'h9ABC_DEF0, "R5 high config readback");
    // pin1 high level, pin2 rising, pin3 falling, pin20 rising field, pin21 falling
    wr(A_CFGLO, (32'h1 << 2) | (32'h2 << 4) | (32'h3 << 6));
    wr(A_CFGHI, (32'h2 << 2*(20-16)) | (32'h3 << 2*(21-16)));
    wr(A_EDGE, 32'h1 << 20);
    repeat (2) step();
    wr(A_STAT, 32'hFFFF_FFFF);
    rdChk(A_STAT, 32'h0, "R9 status cleared by ones");
    wr(A_MASK, 32'h0030_000E);
    rdChk(A_MASK, 32'h0030_000E, "R11 mask readback");

    // R2, R3, R4: direction, output data, readback
    dirM  = 32'h0000_FF0F;
    dataM = 32'hA5A5_5A5A;
    wr(A_DIR, dirM);
    wr(A_DATA, dataM);
    expectVal(K_OE,  A_DATA, dirM,  "R2 padOe follows direction");
    expectVal(K_OUT, A_DATA, dataM, "R2 padOut follows data");
    rdChk(A_DATA, (dataM & dirM) | (padIn & ~dirM), "R3 data read mixes outputs and pads");
    rdChk(A_PAD, padIn, "R4 pad status ignores direction");

    // R6, R13, R4: level-high on pin 1
    padIn[1] = 1'b1;
    rdChk(A_STAT, 32'h0, "R13 no status at once");
    step();
    rdChk(A_STAT, 32'h0, "R13 no status after one edge");
    step();
    rdChk(A_PAD, 32'hFFFF_FFFB, "R4 pad visible after two edges");
    rdChk(A_STAT, 32'h0, "R13 no status after two edges");
    step();
    rdChk(A_STAT, 32'h2, "R6 high level sets status");
    expectVal(K_IRQL, A_DATA, 32'h1, "R12 irqLow from pin 1");
    expectVal(K_IRQH, A_DATA, 32'h0, "R12 irqHigh quiet for pin 1");
    wr(A_STAT, 32'h2);
    rdChk(A_STAT, 32'h2, "R6 clear has no effect while level holds");
    padIn[1] = 1'b0;
    repeat (3) step();
    wr(A_STAT, 32'h2);
    rdChk(A_STAT, 32'h0, "R6 clear works once level drops");
    expectVal(K_IRQL, A_DATA, 32'h0, "R12 irqLow drops after clear");

    // R7: rising on pin 2, falling on pin 3
    padIn[2] = 1'b1;
    repeat (3) step();
    rdChk(A_STAT, 32'h4, "R7 rising edge sets status");
    wr(A_STAT, 32'h4);
    repeat (2) step();
    rdChk(A_STAT, 32'h0, "R7 edge sets status only once");
    padIn[2] = 1'b0;
    repeat (4) step();
    rdChk(A_STAT, 32'h0, "R7 falling edge ignored on rising pin");
    padIn[3] = 1'b0;
    repeat (3) step();
    rdChk(A_STAT, 32'h8, "R7 falling edge sets status");
    wr(A_STAT, 32'h8);
    rdChk(A_STAT, 32'h0, "R9 falling status cleared");

    // R8: pin 20 both edges overrides its rising field
    padIn[20] = 1'b0;
    repeat (3) step();
    rdChk(A_STAT, 32'h1 << 20, "R8 falling edge caught by override");
    expectVal(K_IRQH, A_DATA, 32'h1, "R12 irqHigh from pin 20");
    expectVal(K_IRQL, A_DATA, 32'h0, "R12 irqLow quiet for pin 20");
    wr(A_STAT, 32'h1 << 20);
    padIn[20] = 1'b1;
    repeat (3) step();
    rdChk(A_STAT, 32'h1 << 20, "R8 rising edge caught by override");
    wr(A_STAT, 32'h1 << 20);

    // R11, R9: unmasked pin 17 low level plus pin 21 falling
    padIn[17] = 1'b0;
    padIn[21] = 1'b0;
    repeat (3) step();
    rdChk(A_STAT, (32'h1 << 17) | (32'h1 << 21), "R11 status set regardless of mask");
    padIn[17] = 1'b1;
    repeat (3) step();
    wr(A_STAT, 32'h0);
    rdChk(A_STAT, (32'h1 << 17) | (32'h1 << 21), "R9 writing zeros changes nothing");
    wr(A_STAT, 32'h1 << 17);
    rdChk(A_STAT, 32'h1 << 21, "R9 only the written one clears");
    expectVal(K_IRQH, A_DATA, 32'h1, "R12 irqHigh from pin 21");
    wr(A_STAT, 32'h1 << 21);
    rdChk(A_STAT, 32'h0, "R9 last bit cleared");
    padIn[17] = 1'b0;
    repeat (3) step();
    rdChk(A_STAT, 32'h1 << 17, "R11 masked pin still records");
    expectVal(K_IRQH, A_DATA, 32'h0, "R11 masked pin raises no irq");
    padIn[17] = 1'b1;
    repeat (3) step();
    wr(A_STAT, 32'h1 << 17);

    // R10: clear lands on the same edge as a new rising event on pin 2
    padIn[2] = 1'b1;
    step();
    step();
    busAddr  = A_STAT;
    busWdata = 32'h4;
    busWrite = 1'b1;
    step();
    busWrite = 1'b0;
    rdChk(A_STAT, 32'h4, "R10 set wins over same-cycle clear");

    repeat (2) step();
    done = 1'b1;
    summary();
  end
endmodule